// File: doc/BRIEF.md
# Normalized Min-Sum Check Row Processor

This block produces the check-to-variable messages for one parity row of a quasi-cyclic LDPC decoder. All 32 variable-to-check messages of the row arrive in a single cycle. Each is an 8-bit two's complement fixed-point value with 3 integer bits and 4 fractional bits. For every edge the block returns a message with two parts. Its sign is the parity of the other 31 input signs. Its magnitude is the smallest of the other 31 input magnitudes, multiplied by a normalization factor below one.

The factor is made only from right shifts and additions, so the block has no multiplier. It changes with the decoder's iteration number. Iteration 1 uses one half, iterations 2 and 3 use five eighths, iteration 4 uses three quarters, and every later iteration uses seven eighths. The decoder's controller presents the row with `row_valid` and the current iteration number. The results appear two cycles later with `msg_valid`. A new row can be accepted on every cycle.

Top module: `nms_check_row`

## Requirements
- R1: `msg_valid` is high in the cycle exactly two clock edges after `row_valid` was sampled high, and is low otherwise.
- R2: Each input edge e occupies bits [8e+7:8e] of `v2c_msgs` and is read as two's complement. Its magnitude is the absolute value, and -128 saturates to magnitude 127. Its sign is bit 7.
- R3: Bit 7 of output edge e is the XOR of bit 7 of all input edges other than e.
- R4: Output edge e carries the scaled smallest magnitude among the other edges. The unique edge holding the row minimum therefore gets the scaled second-smallest magnitude.
- R5: When the row minimum magnitude appears on two or more edges, every edge receives the scaled minimum.
- R6: The scaled value of magnitude m is computed from floor terms. For iteration 0 or 1 it is m>>1. For iterations 2 and 3 it is (m>>1)+(m>>3). For iteration 4 it is (m>>1)+(m>>2). For iteration 5 and above it is (m>>1)+(m>>2)+(m>>3).
- R7: Output edge e occupies bits [8e+7:8e] of `c2v_msgs` in sign-magnitude form, with bits 6:0 as the magnitude. The magnitude never exceeds 109.
- R8: While reset is low, `msg_valid` is 0 and `c2v_msgs` is all zeros.
- R9: Rows presented on consecutive cycles each produce their own result, in order, on consecutive cycles. Each result uses the iteration number sampled with its own row.
- R10: `c2v_msgs` holds its value in every cycle that does not deliver a new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| row_valid | input | 1 | Row messages and iteration number are valid this cycle |
| iter_num | input | ITER_W (5) | Current decoder iteration, counted from 1 |
| v2c_msgs | input | NUM_EDGES*MSG_W (256) | Variable-to-check messages, edge e at bits [8e+7:8e] |
| msg_valid | output | 1 | Check-to-variable messages are valid this cycle |
| c2v_msgs | output | NUM_EDGES*MSG_W (256) | Check-to-variable messages, sign-magnitude, edge e at bits [8e+7:8e] |

## Verification
Two functions can fall in the same cycle. In one cycle the first stage may capture a new row and its iteration number while the second stage scales the previous row with a different mode. The bench provokes this by sending rows back to back across the iteration boundaries 3 to 4, 4 to 5 and 5 to 1. Any leak of one row's mode or minima into its neighbour shows up as a mismatch against the reference model, which is compared on every clock. Random rows with random iteration numbers, arriving with and without gaps, repeat the same collision at many more mode pairs.

// File: rtl/nms_pkg.sv
// Package: shared types for the normalized min-sum check row processor.
// Assumes a 2-bit scale selector, with each code naming one shift-add factor.
package nms_pkg;

    typedef enum logic [1:0] {
        SCALE_HALF      = 2'd0,   // m/2
        SCALE_FIVE_8TH  = 2'd1,   // m/2 + m/8
        SCALE_THREE_4TH = 2'd2,   // m/2 + m/4
        SCALE_SEVEN_8TH = 2'd3    // m/2 + m/4 + m/8
    } scale_mode_e;

endpackage

// File: rtl/nms_iter_sched.sv
// Module: maps the decoder iteration number onto a scale mode.
// Assumes iterations count from 1; iteration 0 is treated like iteration 1.
module nms_iter_sched
    import nms_pkg::*;
#(
    parameter int ITER_W = 5
) (
    input  logic [ITER_W-1:0] iter_num,
    output scale_mode_e       mode
);

    // Purpose: choose the factor for the current iteration (fixed from iteration 5 on).
    always_comb begin
        if (iter_num <= ITER_W'(1))       mode = SCALE_HALF;
        else if (iter_num <= ITER_W'(3))  mode = SCALE_FIVE_8TH;
        else if (iter_num == ITER_W'(4))  mode = SCALE_THREE_4TH;
        else                              mode = SCALE_SEVEN_8TH;
    end

endmodule

// File: rtl/nms_edge_unpack.sv
// Module: splits two's complement edge messages into sign bits and magnitudes.
// Assumes MSG_W-bit signed inputs; the most negative code saturates to the top magnitude.
module nms_edge_unpack #(
    parameter int NUM_EDGES = 32,
    parameter int MSG_W     = 8,
    localparam int MAG_W    = MSG_W - 1
) (
    input  logic [NUM_EDGES*MSG_W-1:0] msgs,
    output logic [NUM_EDGES*MAG_W-1:0] mags,
    output logic [NUM_EDGES-1:0]       signs
);

    for (genvar e = 0; e < NUM_EDGES; e++) begin : g_edge
        logic [MSG_W-1:0] raw;
        logic [MSG_W-1:0] absval;

        assign raw = msgs[e*MSG_W +: MSG_W];

        // Purpose: absolute value with saturation of the most negative code.
        always_comb begin
            absval = raw[MSG_W-1] ? (~raw + MSG_W'(1)) : raw;
            if (absval[MSG_W-1]) mags[e*MAG_W +: MAG_W] = '1;
            else                 mags[e*MAG_W +: MAG_W] = absval[MAG_W-1:0];
        end

        assign signs[e] = raw[MSG_W-1];
    end

endmodule

// File: rtl/nms_two_min.sv
// Module: one pass over all magnitudes, returning the smallest value, the
// second smallest value and the position of the smallest.
// Assumes ties keep the lowest position as the minimum and copy the value into the second minimum.
module nms_two_min #(
    parameter int NUM_EDGES = 32,
    parameter int MAG_W     = 7,
    localparam int IDX_W    = $clog2(NUM_EDGES)
) (
    input  logic [NUM_EDGES*MAG_W-1:0] mags,
    output logic [MAG_W-1:0]           min1,
    output logic [MAG_W-1:0]           min2,
    output logic [IDX_W-1:0]           min1_idx
);

    // Purpose: sequential fold that keeps the two smallest magnitudes seen so far.
    always_comb begin
        logic [MAG_W-1:0] v;
        min1     = '1;
        min2     = '1;
        min1_idx = '0;
        for (int e = 0; e < NUM_EDGES; e++) begin
            v = mags[e*MAG_W +: MAG_W];
            if (v < min1) begin
                min2     = min1;
                min1     = v;
                min1_idx = IDX_W'(e);
            end else if (v < min2) begin
                min2 = v;
            end
        end
    end

endmodule

// File: rtl/nms_shift_scale.sv
// Module: multiplies a magnitude by the selected factor using floor shifts and adds.
// Assumes each shifted term is truncated on its own before summing; the sum saturates.
module nms_shift_scale
    import nms_pkg::*;
#(
    parameter int MAG_W = 7
) (
    input  logic [MAG_W-1:0] mag,
    input  scale_mode_e      mode,
    output logic [MAG_W-1:0] scaled
);

    logic [MAG_W:0] t_half, t_quarter, t_eighth, total;

    assign t_half    = {1'b0, mag >> 1};
    assign t_quarter = {1'b0, mag >> 2};
    assign t_eighth  = {1'b0, mag >> 3};

    // Purpose: select which shifted terms are added for the active mode.
    always_comb begin
        unique case (mode)
            SCALE_HALF:      total = t_half;
            SCALE_FIVE_8TH:  total = t_half + t_eighth;
            SCALE_THREE_4TH: total = t_half + t_quarter;
            default:         total = t_half + t_quarter + t_eighth;
        endcase
    end

    // Purpose: clamp to the magnitude range.
    assign scaled = total[MAG_W] ? '1 : total[MAG_W-1:0];

endmodule

// File: rtl/nms_check_row.sv
// Module: normalized min-sum check row processor, two pipeline stages.
// Stage 1 registers the row minima, the minimum position, the sign parity and the scale mode.
// Stage 2 scales both minima once and hands each edge one of them with its
// extrinsic sign. Assumes one row per cycle at most and no stall.
module nms_check_row
    import nms_pkg::*;
#(
    parameter int NUM_EDGES = 32,
    parameter int MSG_W     = 8,
    parameter int ITER_W    = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       row_valid,
    input  logic [ITER_W-1:0]          iter_num,
    input  logic [NUM_EDGES*MSG_W-1:0] v2c_msgs,
    output logic                       msg_valid,
    output logic [NUM_EDGES*MSG_W-1:0] c2v_msgs
);

    localparam int MAG_W = MSG_W - 1;
    localparam int IDX_W = $clog2(NUM_EDGES);

    logic [NUM_EDGES*MAG_W-1:0] mags;
    logic [NUM_EDGES-1:0]       signs;
    logic [MAG_W-1:0]           min1, min2;
    logic [IDX_W-1:0]           min1_idx;
    scale_mode_e                mode;

    logic                       s1_valid;
    logic [MAG_W-1:0]           s1_min1, s1_min2;
    logic [IDX_W-1:0]           s1_idx;
    logic [NUM_EDGES-1:0]       s1_signs;
    logic                       s1_parity;
    scale_mode_e                s1_mode;

    logic [MAG_W-1:0]           sc_min1, sc_min2;
    logic [NUM_EDGES*MSG_W-1:0] next_msgs;

    nms_edge_unpack #(.NUM_EDGES(NUM_EDGES), .MSG_W(MSG_W)) u_unpack (
        .msgs  (v2c_msgs),
        .mags  (mags),
        .signs (signs)
    );

    nms_two_min #(.NUM_EDGES(NUM_EDGES), .MAG_W(MAG_W)) u_two_min (
        .mags     (mags),
        .min1     (min1),
        .min2     (min2),
        .min1_idx (min1_idx)
    );

    nms_iter_sched #(.ITER_W(ITER_W)) u_sched (
        .iter_num (iter_num),
        .mode     (mode)
    );

    // Purpose: stage 1 register of row summary and mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_min1   <= '0;
            s1_min2   <= '0;
            s1_idx    <= '0;
            s1_signs  <= '0;
            s1_parity <= 1'b0;
            s1_mode   <= SCALE_HALF;
        end else begin
            s1_valid <= row_valid;
            if (row_valid) begin
                s1_min1   <= min1;
                s1_min2   <= min2;
                s1_idx    <= min1_idx;
                s1_signs  <= signs;
                s1_parity <= ^signs;
                s1_mode   <= mode;
            end
        end
    end

    nms_shift_scale #(.MAG_W(MAG_W)) u_scale_min1 (
        .mag    (s1_min1),
        .mode   (s1_mode),
        .scaled (sc_min1)
    );

    nms_shift_scale #(.MAG_W(MAG_W)) u_scale_min2 (
        .mag    (s1_min2),
        .mode   (s1_mode),
        .scaled (sc_min2)
    );

    for (genvar e = 0; e < NUM_EDGES; e++) begin : g_out
        logic             ext_sign;
        logic [MAG_W-1:0] ext_mag;
        // Purpose: extrinsic sign and the minimum that excludes this edge.
        always_comb begin
            ext_sign = s1_parity ^ s1_signs[e];
            ext_mag  = (s1_idx == IDX_W'(e)) ? sc_min2 : sc_min1;
        end
        assign next_msgs[e*MSG_W +: MSG_W] = {ext_sign, ext_mag};
    end

    // Purpose: stage 2 output register, loaded only when a row completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_valid <= 1'b0;
            c2v_msgs  <= '0;
        end else begin
            msg_valid <= s1_valid;
            if (s1_valid) c2v_msgs <= next_msgs;
        end
    end

endmodule

// File: rtl/nms_check_row_chk.sv
// Module: property checker bound to nms_check_row.
// Assumes it sees only the top-level ports and keeps its own two-deep history.
module nms_check_row_chk #(
    parameter int NUM_EDGES = 32,
    parameter int MSG_W     = 8,
    parameter int ITER_W    = 5
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       row_valid,
    input logic [ITER_W-1:0]          iter_num,
    input logic [NUM_EDGES*MSG_W-1:0] v2c_msgs,
    input logic                       msg_valid,
    input logic [NUM_EDGES*MSG_W-1:0] c2v_msgs
);

    localparam int MAG_W   = MSG_W - 1;
    localparam int MAG_MAX = (1 << MAG_W) - 1;
    localparam int MAG_CAP = (MAG_MAX >> 1) + (MAG_MAX >> 2) + (MAG_MAX >> 3);
    localparam int HALF_CAP = MAG_MAX >> 1;

    logic v1, v2, par1, par2, half1, half2;
    logic in_par, out_par, all_le_cap, all_le_half;

    // Purpose: fold the input and output sign bits.
    always_comb begin
        in_par      = 1'b0;
        out_par     = 1'b0;
        all_le_cap  = 1'b1;
        all_le_half = 1'b1;
        for (int e = 0; e < NUM_EDGES; e++) begin
            in_par  = in_par  ^ v2c_msgs[e*MSG_W + MSG_W - 1];
            out_par = out_par ^ c2v_msgs[e*MSG_W + MSG_W - 1];
            if (int'(c2v_msgs[e*MSG_W +: MAG_W]) > MAG_CAP)  all_le_cap  = 1'b0;
            if (int'(c2v_msgs[e*MSG_W +: MAG_W]) > HALF_CAP) all_le_half = 1'b0;
        end
    end

    // Purpose: two-deep history of valid, input parity and half-mode iteration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0; v2 <= 1'b0;
            par1 <= 1'b0; par2 <= 1'b0;
            half1 <= 1'b0; half2 <= 1'b0;
        end else begin
            v1    <= row_valid;
            v2    <= v1;
            par1  <= in_par;
            par2  <= par1;
            half1 <= (iter_num <= ITER_W'(1));
            half2 <= half1;
        end
    end

    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid == v2);

    // Each output sign is parity^own, so the XOR over an even count of edges returns the input parity.
    assert_sign_parity_R3: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (out_par == ((NUM_EDGES % 2 == 0) ? par2 : 1'b0)));

    assert_half_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && half2) |-> all_le_half);

    assert_mag_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> all_le_cap);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !v1 |=> $stable(c2v_msgs));

endmodule

bind nms_check_row nms_check_row_chk #(
    .NUM_EDGES (NUM_EDGES),
    .MSG_W     (MSG_W),
    .ITER_W    (ITER_W)
) u_nms_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_valid (row_valid),
    .iter_num  (iter_num),
    .v2c_msgs  (v2c_msgs),
    .msg_valid (msg_valid),
    .c2v_msgs  (c2v_msgs)
);

// File: tb/tb_nms_check_row.sv
// Bench: behavioural reference model of the check row processor, compared every clock.
module tb_nms_check_row;

    localparam int N  = 32;
    localparam int W  = 8;
    localparam int IW = 5;
    localparam int VW = N * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          row_valid = 1'b0;
    logic [IW-1:0] iter_num = '0;
    logic [VW-1:0] v2c_msgs = '0;
    logic          msg_valid;
    logic [VW-1:0] c2v_msgs;

    int compared = 0;
    int mismatched = 0;
    bit run_checks = 1'b0;
    string cur_tag = "none";

    always #5 clk = ~clk;

    nms_check_row #(.NUM_EDGES(N), .MSG_W(W), .ITER_W(IW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .row_valid (row_valid),
        .iter_num  (iter_num),
        .v2c_msgs  (v2c_msgs),
        .msg_valid (msg_valid),
        .c2v_msgs  (c2v_msgs)
    );

    // Reference scale per R6.
    function automatic int ref_scale(input int m, input int it);
        if (it <= 1)      return m / 2;
        else if (it <= 3) return m / 2 + m / 8;
        else if (it == 4) return m / 2 + m / 4;
        else              return m / 2 + m / 4 + m / 8;
    endfunction

    // Reference row: direct exclusion search per edge (R2..R7).
    function automatic logic [VW-1:0] ref_row(input logic [VW-1:0] v, input int it);
        int mag[N];
        bit sg[N];
        logic [VW-1:0] r;
        for (int e = 0; e < N; e++) begin
            int x;
            x = int'($signed(v[e*W +: W]));
            sg[e]  = (x < 0);
            mag[e] = (x < 0) ? -x : x;
            if (mag[e] > 127) mag[e] = 127;
        end
        for (int e = 0; e < N; e++) begin
            int best;
            bit s;
            best = 1000;
            s = 1'b0;
            for (int j = 0; j < N; j++) begin
                if (j != e) begin
                    if (mag[j] < best) best = mag[j];
                    s = s ^ sg[j];
                end
            end
            r[e*W +: W] = {s, 7'(ref_scale(best, it))};
        end
        return r;
    endfunction

    logic          m_v1 = 1'b0;
    logic [VW-1:0] m_d1 = '0;
    string         m_t1 = "none";
    logic          exp_valid = 1'b0;
    logic [VW-1:0] exp_out = '0;
    string         exp_tag = "R8";

    // Reference pipeline timing (R1, R9, R10).
    always @(posedge clk) begin
        if (!rst_n) begin
            m_v1      <= 1'b0;
            exp_valid <= 1'b0;
            exp_out   <= '0;
        end else begin
            exp_valid <= m_v1;
            if (m_v1) begin
                exp_out <= m_d1;
                exp_tag <= m_t1;
            end
            m_v1 <= row_valid;
            if (row_valid) begin
                m_d1 <= ref_row(v2c_msgs, int'(iter_num));
                m_t1 <= cur_tag;
            end
        end
    end

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        if (run_checks) begin
            compared++;
            if (msg_valid !== exp_valid || c2v_msgs !== exp_out) begin
                mismatched++;
                $display("FAIL %s (R1 valid / data): valid %b exp %b, data %h exp %h",
                         exp_tag, msg_valid, exp_valid, c2v_msgs, exp_out);
            end
        end
    end

    task automatic push(input logic [VW-1:0] v, input int it, input string tag);
        @(negedge clk);
        v2c_msgs  = v;
        iter_num  = IW'(it);
        row_valid = 1'b1;
        cur_tag   = tag;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            row_valid = 1'b0;
        end
    endtask

    function automatic logic [VW-1:0] fill(input int base, input int step, input bit alt_neg);
        logic [VW-1:0] v;
        for (int e = 0; e < N; e++) begin
            int x;
            x = base + step * e;
            if (x > 127) x = 127;
            if (alt_neg && (e % 3 == 1)) x = -x;
            v[e*W +: W] = W'(x);
        end
        return v;
    endfunction

    function automatic logic [VW-1:0] rnd_row(inout int seed);
        logic [VW-1:0] v;
        for (int e = 0; e < N; e++) begin
            seed = seed * 1103515245 + 12345;
            v[e*W +: W] = W'(seed >>> 13);
        end
        return v;
    endfunction

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        summary();
    end

    initial begin
        logic [VW-1:0] v;
        int seed;
        seed = 7;
        // R8: reset state.
        repeat (3) @(negedge clk);
        compared++;
        if (msg_valid !== 1'b0 || c2v_msgs !== '0) begin
            mismatched++;
            $display("FAIL R8: valid %b data %h, expected 0 and 0", msg_valid, c2v_msgs);
        end
        rst_n = 1'b1;
        run_checks = 1'b1;

        // R4 R6: distinct positive magnitudes, minimum at edge 0, half factor.
        push(fill(10, 3, 1'b0), 1, "R4 R6 half");
        idle(3);
        // R3 R6: mixed signs, five-eighths.
        push(fill(20, 2, 1'b1), 2, "R3 R6 five-eighths");
        idle(3);
        // R4 R6: minimum at edge 31, three-quarters.
        push(fill(120, -3, 1'b1), 4, "R4 R6 three-quarters min at 31");
        idle(3);
        // R6: seven-eighths on a late iteration.
        push(fill(40, 2, 1'b1), 9, "R6 seven-eighths");
        idle(3);
        // R5: tied minimum on two edges.
        v = fill(60, 1, 1'b0);
        v[5*W +: W]  = W'(-5);
        v[17*W +: W] = W'(5);
        push(v, 3, "R5 tie");
        idle(3);
        // R2 R7: most negative code everywhere, saturation and magnitude cap.
        push({N{8'h80}}, 5, "R2 R7 saturation");
        idle(3);
        // R4: all zero row.
        push('0, 0, "R4 zero row");
        idle(3);
        // R9: back-to-back rows across mode boundaries.
        push(fill(30, 1, 1'b1), 3, "R9 b2b iter3");
        push(fill(70, -2, 1'b0), 4, "R9 b2b iter4");
        push(fill(11, 4, 1'b1), 5, "R9 b2b iter5");
        push(fill(90, -1, 1'b1), 1, "R9 b2b iter1");
        // R10: idle cycles, outputs must hold.
        idle(6);
        // R4 R9: random rows, random iteration numbers, random gaps.
        for (int k = 0; k < 40; k++) begin
            v = rnd_row(seed);
            push(v, k % 12, "R4 R9 random");
            if (k % 5 == 4) idle(k % 3 + 1);
        end
        idle(5);
        summary();
    end

endmodule